// File: doc/BRIEF.md
# Board Interrupt and Slot Status Controller

This block sits on a simple synchronous register bus and merges sixteen external interrupt levels into one host interrupt. Each input is sampled every clock into a raw-level register. An input that newly rises while its enable bit is set latches a pending bit. The pending bit stays set until software rewrites the pending register. The host interrupt line is high whenever any pending bit is also enabled.

The same register space holds plain read/write scratch registers for two LED data words, an LED control word and a small bank of miscellaneous control words. It also holds two card-slot status words. In each slot word, a ready flag and an active-low card-detect flag follow fixed interrupt inputs. Software may change only the five low power and reset control bits of a slot word.

Reads are combinational from the address. Writes take effect at the rising clock edge while the write enable is high. Register offsets: LED data A 0x10, LED data B 0x14, LED control 0x40, miscellaneous words from 0x80 in steps of 4, enable mask 0xC0, raw level 0xC4 (read-only), pending 0xD0, slot 0 status 0xE0, slot 1 status 0xE4.

Top module: `board_ctl`

## Requirements
- R1: After reset, the enable mask, the pending register, the raw level and all scratch registers read 0, irq_o is low, and both slot status words read 0x0000_0420.
- R2: The LED data A (0x10), LED data B (0x14), LED control (0x40) and miscellaneous (0x80 + 4*i) registers read back the full 32-bit value last written.
- R3: Writes to the enable mask (0xC0) and the pending register (0xD0) store value AND 0x000F_EEFF. All other bits read 0.
- R4: A 0-to-1 transition of irq_in_i[n], seen one clock after the previous sample, sets pending bit n when enable bit n is set. Deasserting the input leaves the bit set. Enabling a bit while its input is already high does not set it.
- R5: A write to the pending register replaces its whole content with the masked value, so it can both set and clear bits.
- R6: A rising input whose enable bit is clear leaves the pending register unchanged.
- R7: irq_o is high exactly when (pending AND enable) is nonzero. It follows any write to either register in the same cycle that the register changes.
- R8: Slot 0 bit 5 reads the inverse of irq_in_i[9] and slot 1 bit 5 reads the inverse of irq_in_i[13], one clock after sampling, whatever the enable mask holds.
- R9: A write to a slot status word (0xE0, 0xE4) changes only bits 4:0. Bit 10 (ready) stays 1 and bit 5 keeps following its input.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets, and to the read-only raw-level register (0xC4), change no register.
- R11: If an enabled input rises in the same cycle as a pending-register write, that bit ends up set, whatever value was written.
- R12: The raw-level register (0xC4) reads the input levels sampled at the previous clock edge, in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte offset of the register being accessed |
| wr_en_i | input | 1 | Write strobe; a write happens at the rising edge |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| irq_in_i | input | NUM_IRQ (16) | External interrupt levels, active high |
| irq_o | output | 1 | Host interrupt, active high |

## Verification
The bench targets the non-writable mask holes (bits 8, 12 and above 19). A design that skipped the mask would read them back as ones. It raises an enabled input in the same cycle that software clears the pending register; a design with the wrong priority loses the event. It enables a bit whose input is already high; a level-triggered design would latch a spurious pending bit. It also toggles the card-detect inputs after writing slot control bits; a design whose slot write reaches beyond bits 4:0 would corrupt the ready or detect flags, and one that drops the control bits on an input change would lose them.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam logic [31:0] IRQ_WR_MASK = 32'h000F_EEFF;

  localparam int unsigned OFS_LED_A     = 'h10;
  localparam int unsigned OFS_LED_B     = 'h14;
  localparam int unsigned OFS_LED_CTL   = 'h40;
  localparam int unsigned OFS_MISC_BASE = 'h80;
  localparam int unsigned OFS_EN        = 'hC0;
  localparam int unsigned OFS_RAW       = 'hC4;
  localparam int unsigned OFS_PEND      = 'hD0;
  localparam int unsigned OFS_SLOT0     = 'hE0;
  localparam int unsigned OFS_SLOT1     = 'hE4;

  localparam int unsigned NUM_SLOT      = 2;
  localparam int unsigned SLOT_CTL_W    = 5;
  localparam int unsigned SLOT_NCD_BIT  = 5;
  localparam int unsigned SLOT_RDY_BIT  = 10;
  localparam int unsigned SLOT0_CD_SRC  = 9;
  localparam int unsigned SLOT1_CD_SRC  = 13;

  localparam int unsigned NUM_LED_REGS  = 3;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_LED_A,
    TGT_LED_B,
    TGT_LED_CTL,
    TGT_MISC,
    TGT_EN,
    TGT_RAW,
    TGT_PEND,
    TGT_SLOT0,
    TGT_SLOT1
  } reg_tgt_e;

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_MISC   = 4,
  parameter int unsigned MISC_IDX_W = 2
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output reg_tgt_e              tgt_o,
  output logic [MISC_IDX_W-1:0] misc_idx_o
);

  localparam int unsigned MISC_SPAN = 4 * NUM_MISC;

  logic [ADDR_W-1:0] misc_off;
  assign misc_off = addr_i - ADDR_W'(OFS_MISC_BASE);

  always_comb begin
    tgt_o      = TGT_NONE;
    misc_idx_o = '0;
    case (addr_i)
      ADDR_W'(OFS_LED_A):   tgt_o = TGT_LED_A;
      ADDR_W'(OFS_LED_B):   tgt_o = TGT_LED_B;
      ADDR_W'(OFS_LED_CTL): tgt_o = TGT_LED_CTL;
      ADDR_W'(OFS_EN):      tgt_o = TGT_EN;
      ADDR_W'(OFS_RAW):     tgt_o = TGT_RAW;
      ADDR_W'(OFS_PEND):    tgt_o = TGT_PEND;
      ADDR_W'(OFS_SLOT0):   tgt_o = TGT_SLOT0;
      ADDR_W'(OFS_SLOT1):   tgt_o = TGT_SLOT1;
      default: begin
        // misc_off wraps high for addresses below the bank
        if ((misc_off < ADDR_W'(MISC_SPAN)) && (addr_i[1:0] == 2'b00)) begin
          tgt_o      = TGT_MISC;
          misc_idx_o = misc_off[MISC_IDX_W+1:2];
        end
      end
    endcase
  end

endmodule

// File: rtl/board_ctl_irq.sv
module board_ctl_irq
  import board_ctl_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_in_i,
  input  logic               en_wr_i,
  input  logic               pend_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_IRQ-1:0] raw_q_o,
  output logic [DATA_W-1:0]  en_q_o,
  output logic [DATA_W-1:0]  pend_q_o,
  output logic               irq_o
);

  logic [NUM_IRQ-1:0] raw_q;
  logic [DATA_W-1:0]  en_q, pend_q, en_d, pend_d;
  logic [NUM_IRQ-1:0] rise_set;
  logic [DATA_W-1:0]  set_ext;

  // new edge on an enabled input
  assign rise_set = irq_in_i & ~raw_q & en_q[NUM_IRQ-1:0];
  assign set_ext  = DATA_W'(rise_set);

  always_comb begin
    en_d   = en_wr_i   ? (wdata_i & IRQ_WR_MASK) : en_q;
    pend_d = pend_wr_i ? (wdata_i & IRQ_WR_MASK) : pend_q;
    pend_d = pend_d | set_ext;   // input event wins over a same-cycle write
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      raw_q  <= irq_in_i;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign raw_q_o  = raw_q;
  assign en_q_o   = en_q;
  assign pend_q_o = pend_q;
  assign irq_o    = |(pend_q & en_q);

endmodule

// File: rtl/board_ctl_slot.sv
module board_ctl_slot
  import board_ctl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [SLOT_CTL_W-1:0] ctl_wdata_i,
  input  logic                  cd_level_i,
  output logic [DATA_W-1:0]     status_o
);

  logic [SLOT_CTL_W-1:0] ctl_q;
  logic                  ncd_q;
  logic                  rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      ncd_q <= 1'b1;
      rdy_q <= 1'b1;
    end else begin
      if (wr_i) ctl_q <= ctl_wdata_i;
      ncd_q <= ~cd_level_i;
      rdy_q <= rdy_q;
    end
  end

  always_comb begin
    status_o               = '0;
    status_o[SLOT_CTL_W-1:0] = ctl_q;
    status_o[SLOT_NCD_BIT] = ncd_q;
    status_o[SLOT_RDY_BIT] = rdy_q;
  end

endmodule

// File: rtl/board_ctl.sv
module board_ctl
  import board_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_IRQ  = 16,
  parameter int unsigned NUM_MISC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rd_data_o,
  input  logic [NUM_IRQ-1:0] irq_in_i,
  output logic               irq_o
);

  localparam int unsigned MISC_IDX_W = (NUM_MISC > 1) ? $clog2(NUM_MISC) : 1;
  localparam int unsigned NUM_SCR    = NUM_LED_REGS + NUM_MISC;

  reg_tgt_e              tgt;
  logic [MISC_IDX_W-1:0] misc_idx;

  board_ctl_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_MISC  (NUM_MISC),
    .MISC_IDX_W(MISC_IDX_W)
  ) u_decode (
    .addr_i    (addr_i),
    .tgt_o     (tgt),
    .misc_idx_o(misc_idx)
  );

  logic [NUM_IRQ-1:0] raw_lvl;
  logic [DATA_W-1:0]  en_mask;
  logic [DATA_W-1:0]  pend_bits;

  board_ctl_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_in_i (irq_in_i),
    .en_wr_i  (wr_en_i && (tgt == TGT_EN)),
    .pend_wr_i(wr_en_i && (tgt == TGT_PEND)),
    .wdata_i  (wdata_i),
    .raw_q_o  (raw_lvl),
    .en_q_o   (en_mask),
    .pend_q_o (pend_bits),
    .irq_o    (irq_o)
  );

  logic [DATA_W-1:0] slot_stat [NUM_SLOT];

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam int unsigned CD_SRC = (s == 0) ? SLOT0_CD_SRC : SLOT1_CD_SRC;
    localparam reg_tgt_e    S_TGT  = (s == 0) ? TGT_SLOT0 : TGT_SLOT1;
    board_ctl_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_en_i && (tgt == S_TGT)),
      .ctl_wdata_i(wdata_i[SLOT_CTL_W-1:0]),
      .cd_level_i (irq_in_i[CD_SRC]),
      .status_o   (slot_stat[s])
    );
  end

  logic [DATA_W-1:0] slot0_stat, slot1_stat;
  assign slot0_stat = slot_stat[0];
  assign slot1_stat = slot_stat[1];

  logic [DATA_W-1:0] scr_q [NUM_SCR];

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    logic              hit;
    logic [DATA_W-1:0] q;
    if (g == 0) begin : g_a
      assign hit = (tgt == TGT_LED_A);
    end else if (g == 1) begin : g_b
      assign hit = (tgt == TGT_LED_B);
    end else if (g == 2) begin : g_c
      assign hit = (tgt == TGT_LED_CTL);
    end else begin : g_m
      assign hit = (tgt == TGT_MISC) && (misc_idx == MISC_IDX_W'(g - NUM_LED_REGS));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= '0;
      else if (wr_en_i && hit) q <= wdata_i;
    end
    assign scr_q[g] = q;
  end

  always_comb begin
    rd_data_o = '0;
    case (tgt)
      TGT_LED_A:   rd_data_o = scr_q[0];
      TGT_LED_B:   rd_data_o = scr_q[1];
      TGT_LED_CTL: rd_data_o = scr_q[2];
      TGT_MISC:    rd_data_o = scr_q[NUM_LED_REGS + int'(misc_idx)];
      TGT_EN:      rd_data_o = en_mask;
      TGT_RAW:     rd_data_o = DATA_W'(raw_lvl);
      TGT_PEND:    rd_data_o = pend_bits;
      TGT_SLOT0:   rd_data_o = slot0_stat;
      TGT_SLOT1:   rd_data_o = slot1_stat;
      default:     rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk
  import board_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_IRQ = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_IRQ-1:0] irq_in_i,
  input logic               irq_o,
  input logic [NUM_IRQ-1:0] raw_q,
  input logic [31:0]        en_q,
  input logic [31:0]        pend_q,
  input logic [31:0]        slot0,
  input logic [31:0]        slot1
);

  logic wr_en_reg, wr_pend_reg, wr_slot0;
  assign wr_en_reg   = wr_en_i && (addr_i == ADDR_W'(OFS_EN));
  assign wr_pend_reg = wr_en_i && (addr_i == ADDR_W'(OFS_PEND));
  assign wr_slot0    = wr_en_i && (addr_i == ADDR_W'(OFS_SLOT0));

  // R3
  mask_holes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q & ~IRQ_WR_MASK) == 32'h0) && ((pend_q & ~IRQ_WR_MASK) == 32'h0));

  // R4
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pend_reg |=> (($past(pend_q) & ~pend_q) == 32'h0));

  // R11
  edge_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_reg && (|(irq_in_i & ~raw_q & en_q[NUM_IRQ-1:0]))) |=> irq_o);

  // R7
  mask_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_reg && (wdata_i == 32'h0)) |=> !irq_o);

  // R8
  cd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((slot0[SLOT_NCD_BIT] == !$past(irq_in_i[SLOT0_CD_SRC])) &&
              (slot1[SLOT_NCD_BIT] == !$past(irq_in_i[SLOT1_CD_SRC]))));

  // R9
  slot_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_slot0 |=> ((slot0[SLOT_CTL_W-1:0] == $past(wdata_i[SLOT_CTL_W-1:0])) &&
                  slot0[SLOT_RDY_BIT] && (slot0[9:6] == 4'h0)));

endmodule

bind board_ctl board_ctl_chk #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .irq_in_i(irq_in_i),
  .irq_o   (irq_o),
  .raw_q   (raw_lvl),
  .en_q    (en_mask),
  .pend_q  (pend_bits),
  .slot0   (slot0_stat),
  .slot1   (slot1_stat)
);

// File: tb/tb_board_ctl.sv
`timescale 1ns/1ps
module tb_board_ctl;

  localparam logic [31:0] WMASK = 32'h000F_EEFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = 32'h0;
  logic [31:0] rd_data_o;
  logic [15:0] irq_in_i = 16'h0;
  logic        irq_o;

  always #2.5 clk = ~clk;

  board_ctl dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rd_data_o(rd_data_o),
    .irq_in_i (irq_in_i),
    .irq_o    (irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {31'h0, irq_o} : rd_data_o;
        n_vec++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr_i = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'h0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_with_in(input logic [7:0] a, input logic [31:0] d, input logic [15:0] v);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; irq_in_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_in(input logic [15:0] v);
    @(negedge clk);
    irq_in_i = v;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    exp_rd(8'hC0, 32'h0, "R1 enable");
    exp_rd(8'hD0, 32'h0, "R1 pending");
    exp_rd(8'hC4, 32'h0, "R1 raw");
    exp_irq(1'b0, "R1 irq");
    exp_rd(8'hE0, 32'h420, "R1 slot0");
    exp_rd(8'hE4, 32'h420, "R1 slot1");
    exp_rd(8'h10, 32'h0, "R1 led a");

    // R2 scratch
    wr(8'h10, 32'hA5A5_1234);
    wr(8'h14, 32'h0F0F_0F0F);
    wr(8'h40, 32'h8000_0003);
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4 * i), 32'h1000 + i);
    exp_rd(8'h10, 32'hA5A5_1234, "R2 led a");
    exp_rd(8'h14, 32'h0F0F_0F0F, "R2 led b");
    exp_rd(8'h40, 32'h8000_0003, "R2 led ctl");
    for (int i = 0; i < 4; i++) exp_rd(8'h80 + 8'(4 * i), 32'h1000 + i, "R2 misc");

    // R3 write masks, R7 irq follows writes
    wr(8'hC0, 32'hFFFF_FFFF);
    exp_rd(8'hC0, WMASK, "R3 enable mask");
    wr(8'hD0, 32'hFFFF_FFFF);
    exp_rd(8'hD0, WMASK, "R3 pending mask");
    exp_irq(1'b1, "R7 irq on pending write");
    wr(8'hD0, 32'h0);
    exp_irq(1'b0, "R7 irq cleared by pending write");
    wr(8'hC0, 32'h0000_1100);
    exp_rd(8'hC0, 32'h0, "R3 hole bits 8 and 12");

    // R4 edge sets pending, sticky
    wr(8'hC0, 32'h1);
    set_in(16'h0001);
    exp_rd(8'hC4, 32'h1, "R12 raw level");
    exp_rd(8'hD0, 32'h1, "R4 pending set");
    exp_irq(1'b1, "R4 irq");
    set_in(16'h0000);
    exp_rd(8'hD0, 32'h1, "R4 sticky");
    exp_irq(1'b1, "R4 irq sticky");
    exp_rd(8'hC4, 32'h0, "R12 raw low");

    // R5 replace
    wr(8'hD0, 32'h0);
    exp_rd(8'hD0, 32'h0, "R5 cleared");
    wr(8'hD0, 32'h0000_0010);
    exp_rd(8'hD0, 32'h10, "R5 set by write");
    exp_irq(1'b0, "R7 pending not enabled");
    wr(8'hC0, 32'h11);
    exp_irq(1'b1, "R7 enable raises irq");
    wr(8'hC0, 32'h1);
    exp_irq(1'b0, "R7 enable drops irq");
    wr(8'hD0, 32'h0);

    // R6 disabled input, then enable while high
    set_in(16'h0002);
    exp_rd(8'hD0, 32'h0, "R6 disabled rise");
    wr(8'hC0, 32'h3);
    exp_rd(8'hD0, 32'h0, "R4 enable while high");
    exp_irq(1'b0, "R4 no irq while high");
    set_in(16'h0000);

    // R11 same-cycle priority
    wr(8'hC0, 32'h4);
    wr_with_in(8'hD0, 32'h0, 16'h0004);
    exp_rd(8'hD0, 32'h4, "R11 input beats write");
    exp_irq(1'b1, "R11 irq");
    wr(8'hD0, 32'h0);
    exp_rd(8'hD0, 32'h0, "R5 clear with input held");
    set_in(16'h0000);

    // R8 card detect
    set_in(16'h0200);
    exp_rd(8'hE0, 32'h400, "R8 slot0 detect");
    exp_rd(8'hE4, 32'h420, "R8 slot1 idle");
    set_in(16'h2000);
    exp_rd(8'hE0, 32'h420, "R8 slot0 released");
    exp_rd(8'hE4, 32'h400, "R8 slot1 detect");
    set_in(16'h0000);
    exp_rd(8'hE4, 32'h420, "R8 slot1 released");

    // R9 slot writes
    wr(8'hE0, 32'hFFFF_FFFF);
    exp_rd(8'hE0, 32'h43F, "R9 slot0 ctl only");
    wr(8'hE4, 32'h0000_0015);
    exp_rd(8'hE4, 32'h435, "R9 slot1 ctl");
    set_in(16'h2000);
    exp_rd(8'hE4, 32'h415, "R9 ctl kept on detect");
    set_in(16'h0000);
    wr(8'hE0, 32'h0);
    exp_rd(8'hE0, 32'h420, "R9 slot0 ctl cleared");

    // R10 unmapped and read-only
    wr(8'h44, 32'hDEAD_BEEF);
    exp_rd(8'h44, 32'h0, "R10 unmapped read");
    exp_rd(8'h10, 32'hA5A5_1234, "R10 led a intact");
    exp_rd(8'hC0, 32'h4, "R10 enable intact");
    wr(8'hC4, 32'h0000_FFFF);
    exp_rd(8'hC4, 32'h0, "R10 raw read-only");
    exp_rd(8'hD0, 32'h0, "R10 pending intact");
    exp_rd(8'h90, 32'h0, "R10 past misc bank");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule